// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a running BCD calendar and raises an alarm when the current time agrees with a programmed alarm time. The calendar counter outside the block supplies five BCD fields: seconds, minutes, hours, day of month and weekday. It also supplies a single-cycle strobe at the start of each new second. The block holds one alarm register for each of the five fields, a sticky alarm flag and an interrupt enable bit.

Software reaches these registers through a byte-wide port made of an address, write data, a write strobe and combinational read data. Each alarm register carries a disable bit, so any subset of fields can take part in the comparison. The flag sets on a matching second and stays set until software writes a zero to it. The interrupt line is active low and open-drain, so the block drives an output-enable for the pull-down and never drives a high level.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the alarm flag is 0, the interrupt enable is 0 and irqOe is 0. Every alarm register reads 0x80, which marks the field as disabled, and the control register reads 0x00.
- R2: The alarm registers sit at addresses 0x0A (seconds), 0x0B (minutes), 0x0C (hours), 0x0D (day of month) and 0x0E (weekday). Each stores the full written byte and reads it back unchanged in the next cycle.
- R3: The comparison uses only the low 7 bits for seconds and minutes, the low 6 bits for hours and day of month, and the low 3 bits for weekday. Alarm bits above these widths, other than bit 7, do not affect the match.
- R4: The flag sets at the clock edge where secTick is 1 and every enabled field equals its calendar field. A match without secTick, or a tick without a match, does not set it.
- R5: A field whose alarm register has bit 7 set is left out of the comparison.
- R6: When bit 7 is set in all five alarm registers, the flag never sets.
- R7: The control register sits at address 0x01 and the flag is its bit 4. Writing 0 to bit 4 clears the flag at the next edge, and writing 1 leaves it as it is. If a matching tick and a clearing write fall in the same cycle, the flag ends up set.
- R8: The interrupt enable is bit 1 of the control register. irqOe equals the flag AND the enable, and it follows either of them with no added register delay.
- R9: A read from any address other than 0x01 or 0x0A to 0x0E returns 0x00. A write to such an address changes no register.
- R10: The control register reads back the flag in bit 4 and the enable in bit 1, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| rdData | output | 8 | Read data for regAddr (combinational) |
| calSec | input | 7 | Calendar seconds, BCD |
| calMin | input | 7 | Calendar minutes, BCD |
| calHour | input | 6 | Calendar hours, BCD |
| calMday | input | 6 | Calendar day of month, BCD |
| calWday | input | 3 | Calendar weekday |
| secTick | input | 1 | One-cycle pulse on each new second |
| alarmFlag | output | 1 | Sticky alarm flag |
| irqOe | output | 1 | Enable for the open-drain, active-low interrupt pull-down |

## Verification
Directed cases cover the following patterns:
- A single enabled field. This separates per-field selection from a full-time match.
- Junk written in the bits above each field width. This shows whether the comparison masks each field to its own width.
- All five fields disabled. This separates "nothing enabled" from "everything matches".
- A matching time held with no tick. This checks that evaluation is tied to the second strobe.
- A clearing write in the same cycle as a matching tick. This pins down which of the two wins.

Constrained-random rounds then mix disabled, matching and mismatching fields with random control writes. A bench model predicts the flag and interrupt after every tick.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 8;
  localparam int NUM_FIELDS = 5;
  localparam int SEC_W      = 7;
  localparam int MIN_W      = 7;
  localparam int HOUR_W     = 6;
  localparam int MDAY_W     = 6;
  localparam int WDAY_W     = 3;

  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 8'h01;
  localparam logic [ADDR_W-1:0] ALARM_BASE = 8'h0A;
  localparam int FLAG_BIT = 4;
  localparam int IEN_BIT  = 1;
  localparam int DIS_BIT  = DATA_W - 1;

  // Compare mask per field index (0 seconds .. 4 weekday)
  function automatic logic [DATA_W-1:0] fieldMask(input int idx);
    case (idx)
      0:       return DATA_W'((1 << SEC_W) - 1);
      1:       return DATA_W'((1 << MIN_W) - 1);
      2:       return DATA_W'((1 << HOUR_W) - 1);
      3:       return DATA_W'((1 << MDAY_W) - 1);
      default: return DATA_W'((1 << WDAY_W) - 1);
    endcase
  endfunction

  typedef struct packed {
    logic                  ctrlRd;
    logic                  ctrlWr;
    logic                  flagClr;
    logic [NUM_FIELDS-1:0] alarmRd;
    logic [NUM_FIELDS-1:0] alarmWr;
  } strobe_t;
endpackage

// File: rtl/rtc_alarm_decode.sv
`timescale 1ns/1ps
module rtc_alarm_decode
  import rtc_alarm_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output strobe_t           strobes
);
  logic                  hitCtrl;
  logic [NUM_FIELDS-1:0] hitAlarm;

  assign hitCtrl = (regAddr == CTRL_ADDR);

  genvar g;
  generate
    for (g = 0; g < NUM_FIELDS; g++) begin : gHit
      assign hitAlarm[g] = (regAddr == ALARM_BASE + ADDR_W'(g));
    end
  endgenerate

  always_comb begin
    strobes         = '0;
    strobes.ctrlRd  = hitCtrl;
    strobes.ctrlWr  = hitCtrl && regWrEn;
    strobes.flagClr = hitCtrl && regWrEn && !regWrData[FLAG_BIT];
    strobes.alarmRd = hitAlarm;
    strobes.alarmWr = hitAlarm & {NUM_FIELDS{regWrEn}};
  end
endmodule

// File: rtl/rtc_alarm_datapath.sv
`timescale 1ns/1ps
module rtc_alarm_datapath
  import rtc_alarm_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  strobe_t                             strobes,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0]   calVec,
  input  logic                                secTick,
  output logic [DATA_W-1:0]                   rdData,
  output logic                                alarmFlag,
  output logic                                irqEn
);
  localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'(1) << DIS_BIT;

  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarmView;
  logic [NUM_FIELDS-1:0]             fieldHit;
  logic [NUM_FIELDS-1:0]             fieldUsed;
  logic                              anyMatch;
  logic                              flagQ;
  logic                              ienQ;

  genvar g;
  generate
    for (g = 0; g < NUM_FIELDS; g++) begin : gField
      localparam logic [DATA_W-1:0] MASK = fieldMask(g);
      logic [DATA_W-1:0] valueQ;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  valueQ <= RESET_VAL;
        else if (strobes.alarmWr[g]) valueQ <= wrData;
      end

      assign alarmView[g] = valueQ;
      assign fieldUsed[g] = ~valueQ[DIS_BIT];
      assign fieldHit[g]  = valueQ[DIS_BIT] | ((valueQ & MASK) == (calVec[g] & MASK));
    end
  endgenerate

  // At least one field must take part; all enabled fields must agree
  assign anyMatch = (&fieldHit) & (|fieldUsed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagQ <= 1'b0;
      ienQ  <= 1'b0;
    end else begin
      if (secTick && anyMatch)  flagQ <= 1'b1;
      else if (strobes.flagClr) flagQ <= 1'b0;
      if (strobes.ctrlWr)       ienQ  <= wrData[IEN_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.ctrlRd) begin
      rdData[FLAG_BIT] = flagQ;
      rdData[IEN_BIT]  = ienQ;
    end
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (strobes.alarmRd[i]) rdData = rdData | alarmView[i];
    end
  end

  assign alarmFlag = flagQ;
  assign irqEn     = ienQ;
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output logic [DATA_W-1:0] rdData,
  input  logic [SEC_W-1:0]  calSec,
  input  logic [MIN_W-1:0]  calMin,
  input  logic [HOUR_W-1:0] calHour,
  input  logic [MDAY_W-1:0] calMday,
  input  logic [WDAY_W-1:0] calWday,
  input  logic              secTick,
  output logic              alarmFlag,
  output logic              irqOe
);
  strobe_t                           strobes;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] calVec;
  logic                              irqEn;

  assign calVec[0] = DATA_W'(calSec);
  assign calVec[1] = DATA_W'(calMin);
  assign calVec[2] = DATA_W'(calHour);
  assign calVec[3] = DATA_W'(calMday);
  assign calVec[4] = DATA_W'(calWday);

  rtc_alarm_decode u_decode (
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .strobes   (strobes)
  );

  rtc_alarm_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .wrData    (regWrData),
    .calVec    (calVec),
    .secTick   (secTick),
    .rdData    (rdData),
    .alarmFlag (alarmFlag),
    .irqEn     (irqEn)
  );

  assign irqOe = alarmFlag & irqEn;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
`timescale 1ns/1ps
module rtc_alarm_match_chk
  import rtc_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              regWrEn,
  input logic [DATA_W-1:0] rdData,
  input logic              secTick,
  input logic              alarmFlag,
  input logic              irqOe
);
  logic mapped;
  logic ctrlClear;
  logic ienClear;

  assign mapped    = (regAddr == CTRL_ADDR) ||
                     ((regAddr >= ALARM_BASE) && (32'(regAddr) < 32'(ALARM_BASE) + NUM_FIELDS));
  assign ctrlClear = regWrEn && (regAddr == CTRL_ADDR) && !regWrData[FLAG_BIT];
  assign ienClear  = regWrEn && (regAddr == CTRL_ADDR) && !regWrData[IEN_BIT];

  assert_flag_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarmFlag) |-> $past(secTick));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlClear && !secTick) |=> !alarmFlag);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarmFlag && !ctrlClear) |=> alarmFlag);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irqOe |-> alarmFlag);

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ienClear |=> !irqOe);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (rdData == '0));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (.*);

// File: tb/rtc_alarm_match_tb.sv
`timescale 1ns/1ps
module rtc_alarm_match_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       regWrEn = 1'b0;
  logic       secTick = 1'b0;
  logic [6:0] calSec = '0;
  logic [6:0] calMin = '0;
  logic [5:0] calHour = '0;
  logic [5:0] calMday = '0;
  logic [2:0] calWday = '0;
  logic [7:0] rdData;
  logic       alarmFlag;
  logic       irqOe;

  int checks = 0;
  int errors = 0;

  logic [4:0][7:0] mAlarm;
  logic [4:0][7:0] cal;
  bit              mFlag;
  bit              mIen;

  always #2 clk = ~clk;

  rtc_alarm_match u_dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .rdData(rdData), .calSec(calSec), .calMin(calMin),
    .calHour(calHour), .calMday(calMday), .calWday(calWday),
    .secTick(secTick), .alarmFlag(alarmFlag), .irqOe(irqOe)
  );

  function automatic logic [7:0] benchMask(input int i);
    if (i < 2) return 8'h7F;
    if (i < 4) return 8'h3F;
    return 8'h07;
  endfunction

  function automatic bit expectMatch(input logic [4:0][7:0] a, input logic [4:0][7:0] c);
    bit any = 0;
    bit all = 1;
    for (int i = 0; i < 5; i++) begin
      if (!a[i][7]) begin
        any = 1;
        if ((a[i] & benchMask(i)) != (c[i] & benchMask(i))) all = 0;
      end
    end
    return any && all;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic setCal(input logic [4:0][7:0] c);
    cal = c;
  endtask

  // One cycle: optional write, optional tick; model updated after the edge
  task automatic step(input bit we, input logic [7:0] addr, input logic [7:0] data, input bit tick);
    bit setNow;
    @(negedge clk);
    regAddr = addr; regWrData = data; regWrEn = we; secTick = tick;
    calSec = cal[0][6:0]; calMin = cal[1][6:0]; calHour = cal[2][5:0];
    calMday = cal[3][5:0]; calWday = cal[4][2:0];
    @(negedge clk);
    regWrEn = 1'b0; secTick = 1'b0;
    setNow = tick && expectMatch(mAlarm, cal);
    if (we && addr == 8'h01) mIen = data[1];
    if (setNow) mFlag = 1;
    else if (we && addr == 8'h01 && !data[4]) mFlag = 0;
    if (we && addr >= 8'h0A && addr <= 8'h0E) mAlarm[addr - 8'h0A] = data;
    #1;
  endtask

  task automatic checkOut(input string req);
    check(alarmFlag == mFlag, req, "alarmFlag", int'(alarmFlag), int'(mFlag));
    check(irqOe == (mFlag && mIen), req, "irqOe", int'(irqOe), int'(mFlag && mIen));
  endtask

  task automatic readCheck(input logic [7:0] addr, input logic [7:0] exp, input string req);
    @(negedge clk);
    regAddr = addr;
    #1;
    check(rdData == exp, req, $sformatf("read 0x%02h", addr), int'(rdData), int'(exp));
  endtask

  function automatic logic [7:0] ctrlExp();
    return {3'b000, mFlag, 2'b00, mIen, 1'b0};
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [4:0][7:0] c;
    void'($urandom(32'h5EED_A1A4));
    mAlarm = {5{8'h80}}; mFlag = 0; mIen = 0; cal = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 / R10: reset state
    checkOut("R1");
    for (int i = 0; i < 5; i++) readCheck(8'h0A + 8'(i), 8'h80, "R1");
    readCheck(8'h01, 8'h00, "R10");

    // R2: full-byte readback at each address
    for (int i = 0; i < 5; i++) begin
      step(1, 8'h0A + 8'(i), 8'hA5 ^ 8'(i * 17), 0);
      readCheck(8'h0A + 8'(i), 8'hA5 ^ 8'(i * 17), "R2");
    end
    for (int i = 0; i < 5; i++) step(1, 8'h0A + 8'(i), 8'h80, 0);

    // R4 / R5: only seconds enabled; match held without tick
    c = '0; c[0] = 8'h30; c[1] = 8'h11; c[2] = 8'h07;
    setCal(c);
    step(1, 8'h0A, 8'h30, 0);
    step(0, 8'h00, 8'h00, 0);
    step(0, 8'h00, 8'h00, 0);
    checkOut("R4 no tick");
    c[0] = 8'h31; setCal(c);
    step(0, 8'h00, 8'h00, 1);
    checkOut("R4 tick mismatch");
    c[0] = 8'h30; c[1] = 8'h59; setCal(c);
    step(0, 8'h00, 8'h00, 1);
    check(alarmFlag == 1'b1, "R5", "flag with other fields disabled", int'(alarmFlag), 1);
    checkOut("R4");

    // R7: writing 1 keeps, writing 0 clears
    step(1, 8'h01, 8'h10, 0);
    check(alarmFlag == 1'b1, "R7", "flag after writing 1", int'(alarmFlag), 1);
    readCheck(8'h01, ctrlExp(), "R10");
    step(1, 8'h01, 8'h00, 0);
    check(alarmFlag == 1'b0, "R7", "flag after writing 0", int'(alarmFlag), 0);

    // R7: clear and matching tick in the same cycle, set wins
    step(1, 8'h01, 8'h00, 1);
    check(alarmFlag == 1'b1, "R7", "set beats clear", int'(alarmFlag), 1);

    // R8: enable drives irqOe; disabling drops it
    step(1, 8'h01, 8'h12, 0);
    check(irqOe == 1'b1, "R8", "irqOe with enable", int'(irqOe), 1);
    readCheck(8'h01, 8'h12, "R10");
    step(1, 8'h01, 8'h10, 0);
    check(irqOe == 1'b0, "R8", "irqOe after disable", int'(irqOe), 0);
    step(1, 8'h01, 8'h02, 0);
    check(irqOe == 1'b0, "R8", "irqOe with flag clear", int'(irqOe), 0);

    // R3: junk above the field width is ignored
    step(1, 8'h0A, 8'h80, 0);
    step(1, 8'h0C, 8'h52, 0);
    c = '0; c[2] = 8'h12; setCal(c);
    step(0, 8'h00, 8'h00, 1);
    check(alarmFlag == 1'b1, "R3", "hour bit 6 ignored", int'(alarmFlag), 1);
    step(1, 8'h01, 8'h00, 0);
    step(1, 8'h0C, 8'h80, 0);
    step(1, 8'h0E, 8'h7D, 0);
    c = '0; c[4] = 8'h05; setCal(c);
    step(0, 8'h00, 8'h00, 1);
    check(alarmFlag == 1'b1, "R3", "weekday upper bits ignored", int'(alarmFlag), 1);
    step(1, 8'h01, 8'h00, 0);
    step(1, 8'h0E, 8'h80, 0);

    // R6: all disabled, several ticks with varied time
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < 5; i++) c[i] = 8'($urandom);
      setCal(c);
      step(0, 8'h00, 8'h00, 1);
      check(alarmFlag == 1'b0, "R6", "flag with all disabled", int'(alarmFlag), 0);
    end

    // R9: unmapped reads are zero and writes are ignored
    step(1, 8'h20, 8'hFF, 0);
    step(1, 8'h0F, 8'h3C, 0);
    readCheck(8'h20, 8'h00, "R9");
    readCheck(8'h00, 8'h00, "R9");
    readCheck(8'h0F, 8'h00, "R9");
    for (int i = 0; i < 5; i++) readCheck(8'h0A + 8'(i), mAlarm[i], "R9");
    readCheck(8'h01, ctrlExp(), "R9");

    // Random mix: R4 R5 R7 R8 against the bench model
    for (int it = 0; it < 400; it++) begin
      for (int i = 0; i < 5; i++) c[i] = 8'($urandom) & benchMask(i);
      setCal(c);
      for (int i = 0; i < 5; i++) begin
        int r = $urandom % 4;
        if (r == 0) step(1, 8'h0A + 8'(i), 8'h80 | 8'($urandom), 0);
        else if (r == 1) step(1, 8'h0A + 8'(i), c[i] | (8'($urandom) & ~benchMask(i) & 8'h7F), 0);
        else if (r == 2 && ($urandom % 3 == 0)) step(1, 8'h0A + 8'(i), 8'($urandom) & 8'h7F, 0);
      end
      if ($urandom % 4 == 0) step(1, 8'h01, 8'($urandom), $urandom % 2);
      else step(0, 8'h00, 8'h00, 1);
      checkOut("R4 random");
      if (it % 16 == 0) readCheck(8'h01, ctrlExp(), "R10 random");
    end

    finishRun();
  end
endmodule